// File: doc/BRIEF.md
# Interrupt Source Controller

This block collects three interrupt sources for a small 8-bit core: an external pin whose active edge can be chosen, a one-cycle overflow pulse from an 8-bit timer, and an 8-bit input port that is watched for level changes on selected pins. Each source has a sticky flag and an enable bit. A small register interface lets software read and write the flags, the enables, a global enable, the edge choice and the port pin mask.

Two outputs go to the core. `wake` rises when any source has both its flag and its enable set, whatever the global enable, so a sleeping core can resume. `irq` also needs the global enable. When the core accepts the request on `core_take`, the block sends out `vec_pulse` and clears the global enable. A later `ret_strobe` sets it again. The external pin and the port inputs are asynchronous and pass through a two-stage synchronizer before detection. The timer pulse is already in the block's clock domain.

Register map (`reg_addr`): 0 is control, 1 is edge configuration, 2 is the port mask, and 3 reads as zero. Control bits: [0] external flag, [1] timer flag, [2] port-change flag, [3] reads zero, [4] external enable, [5] timer enable, [6] port-change enable, [7] global enable. Edge configuration bit [0] is 1 for the rising edge and 0 for the falling edge. Reads are combinational.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, control reads 8'h00, the port mask reads 8'h00, edge configuration reads 8'h01, and `irq`, `wake` and `vec_pulse` are 0.
- R2: With edge configuration bit [0] = 1, a rising edge on `ext_pin` sets control bit [0]. A falling edge leaves it clear.
- R3: With edge configuration bit [0] = 0, a falling edge on `ext_pin` sets control bit [0]. A rising edge leaves it clear.
- R4: A cycle with `tmr_ovf` high sets control bit [1] at the next clock edge.
- R5: A level change on port pin i sets control bit [2] only when mask bit i is 1. Changes on pins whose mask bit is 0 never set it.
- R6: A flag stays set until software writes a 0 to it at address 0. If a hardware set and that write of 0 fall in the same cycle, the flag ends up set.
- R7: `wake` is 1 exactly when some flag and its enable (control bit n and bit n+4) are both 1, independent of control bit [7].
- R8: `irq` is 1 exactly when `wake` is 1 and control bit [7] is 1.
- R9: `vec_pulse` equals `core_take` AND `irq`. A pulse clears control bit [7] at the next edge, and `ret_strobe` sets it at the next edge. A clear from `vec_pulse` takes priority over `ret_strobe` and over register writes.
- R10: A change on `ext_pin` or `port_in` shows in its flag after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_in | input | 8 | Port inputs watched for change, asynchronous |
| tmr_ovf | input | 1 | One-cycle timer wrap pulse (FFh to 00h) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| core_take | input | 1 | Core accepts the interrupt vector |
| ret_strobe | input | 1 | Return from interrupt, sets the global enable |
| vec_pulse | output | 1 | Vector-taken pulse |
| irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request to a sleeping core |

## Verification
The assertions assume that `tmr_ovf` is a pulse synchronous to `clk`, and that `core_take` and `ret_strobe` are single-cycle strobes sampled on the rising edge. The stimulus drives every input on the falling edge and holds the asynchronous pins steady for several cycles, so no edge is shorter than the synchronizer can capture. Each test clears the flags and enables before it starts, so a request left over from an earlier test cannot change the result.

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter int SYNC_N = 2,
  parameter int AW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_pin,
  input  logic [7:0]    port_in,
  input  logic          tmr_ovf,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          core_take,
  input  logic          ret_strobe,
  output logic          vec_pulse,
  output logic          irq,
  output logic          wake
);
  localparam int PW = 8;

  logic [SYNC_N-1:0]         ext_sync;
  logic [SYNC_N-1:0][PW-1:0] port_sync;
  logic                      ext_prev;
  logic [PW-1:0]             port_prev;
  logic [2:0]                flag_q, en_q;
  logic                      gie_q, rise_q;
  logic [PW-1:0]             mask_q;

  wire ext_s  = ext_sync[SYNC_N-1];
  wire [PW-1:0] port_s = port_sync[SYNC_N-1];
  wire ext_set = rise_q ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
  wire chg_set = |((port_s ^ port_prev) & mask_q);
  wire [2:0] hw_set = {chg_set, tmr_ovf, ext_set};
  wire ctl_wr = reg_we && reg_addr == AW'(0);
  wire cfg_wr = reg_we && reg_addr == AW'(1);
  wire msk_wr = reg_we && reg_addr == AW'(2);

  assign wake      = |(flag_q & en_q);
  assign irq       = gie_q & wake;
  assign vec_pulse = core_take & irq;

  always_comb
    case (reg_addr)
      AW'(0):  reg_rdata = {gie_q, en_q, 1'b0, flag_q};
      AW'(1):  reg_rdata = {7'd0, rise_q};
      AW'(2):  reg_rdata = mask_q;
      default: reg_rdata = 8'd0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_sync  <= '0;
      port_sync <= '0;
      ext_prev  <= 1'b0;
      port_prev <= '0;
    end else begin
      ext_sync  <= {ext_sync[SYNC_N-2:0], ext_pin};
      port_sync <= {port_sync[SYNC_N-2:0], port_in};
      ext_prev  <= ext_s;
      port_prev <= port_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
      rise_q <= 1'b1;
      mask_q <= '0;
    end else begin
      flag_q <= hw_set | (ctl_wr ? reg_wdata[2:0] : flag_q);
      if (ctl_wr) en_q <= reg_wdata[6:4];
      if (vec_pulse)       gie_q <= 1'b0;
      else if (ret_strobe) gie_q <= 1'b1;
      else if (ctl_wr)     gie_q <= reg_wdata[7];
      if (cfg_wr) rise_q <= reg_wdata[0];
      if (msk_wr) mask_q <= reg_wdata;
    end

  AST_EXT_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n) ext_set |=> flag_q[0]); // R6
  AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) tmr_ovf |=> flag_q[1]); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[2] && !(ctl_wr && !reg_wdata[2])) |=> flag_q[2]); // R6
  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n) vec_pulse |=> !gie_q); // R9
  AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !vec_pulse) |=> gie_q); // R9
  AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> wake); // R8
  AST_NO_FLAG_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (flag_q == 3'd0) |-> !wake); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'd0 && !(ctl_wr && reg_wdata[2]) && !flag_q[2]) |=> !flag_q[2]); // R5
endmodule

// File: tb/sim_irq_source_ctrl.sv
module sim_irq_source_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_pin = 1'b0, tmr_ovf = 1'b0, reg_we = 1'b0, core_take = 1'b0, ret_strobe = 1'b0;
  logic [7:0] port_in = 8'd0, reg_wdata = 8'd0, reg_rdata;
  logic [1:0] reg_addr = 2'd0;
  logic vec_pulse, irq, wake;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_source_ctrl u0 (.clk, .rst_n, .ext_pin, .port_in, .tmr_ovf, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .core_take, .ret_strobe, .vec_pulse, .irq, .wake);

  // {mask, port value, expected port-change flag}
  localparam logic [16:0] VEC [8] = '{
    {8'hFF, 8'h01, 1'b1}, {8'h01, 8'h03, 1'b0}, {8'h02, 8'h01, 1'b1}, {8'hF0, 8'h0F, 1'b0},
    {8'h08, 8'h07, 1'b1}, {8'h80, 8'h87, 1'b1}, {8'h7F, 8'h07, 1'b0}, {8'h00, 8'h00, 1'b0}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 edge", v, 8'h01);
    rd(2, v); chk("R1 mask", v, 8'h00);
    chk("R1 outs", {5'd0, irq, wake, vec_pulse}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr(2, VEC[i][16:9]);
      wr(0, 8'h00);
      @(negedge clk); port_in = VEC[i][8:1];
      repeat (4) @(negedge clk);
      rd(0, v); chk($sformatf("R5 vec%0d", i), {7'd0, v[2]}, {7'd0, VEC[i][0]});
    end

    // R2 rising, with R10 latency
    @(negedge clk); ext_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R10 not yet", {7'd0, v[0]}, 8'd0);
    @(negedge clk);
    rd(0, v); chk("R10/R2 rise sets", {7'd0, v[0]}, 8'd1);
    wr(0, 8'h00);
    @(negedge clk); ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, v); chk("R2 fall ignored", {7'd0, v[0]}, 8'd0);

    // R3 falling mode
    wr(1, 8'h00);
    @(negedge clk); ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(0, v); chk("R3 rise ignored", {7'd0, v[0]}, 8'd0);
    @(negedge clk); ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, v); chk("R3 fall sets", {7'd0, v[0]}, 8'd1);
    wr(0, 8'h00);

    // R4 timer
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    rd(0, v); chk("R4 timer flag", {7'd0, v[1]}, 8'd1);
    repeat (5) @(negedge clk);
    rd(0, v); chk("R6 sticky", {7'd0, v[1]}, 8'd1);
    wr(0, 8'h00);
    rd(0, v); chk("R6 sw clear", {7'd0, v[1]}, 8'd0);
    @(negedge clk); tmr_ovf = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
    @(negedge clk); tmr_ovf = 1'b0; reg_we = 1'b0;
    rd(0, v); chk("R6 set wins", {7'd0, v[1]}, 8'd1);

    // R7 / R8 / R9
    wr(0, 8'h02);
    chk("R7 no enable", {7'd0, wake}, 8'd0);
    wr(0, 8'h22);
    chk("R7 wake w/o gie", {6'd0, wake, irq}, 8'h02);
    core_take = 1'b1; #1;
    chk("R9 no pulse w/o irq", {7'd0, vec_pulse}, 8'd0);
    @(negedge clk); core_take = 1'b0;
    wr(0, 8'hA2);
    chk("R8 irq with gie", {7'd0, irq}, 8'd1);
    @(negedge clk); core_take = 1'b1; #1;
    chk("R9 pulse", {7'd0, vec_pulse}, 8'd1);
    @(negedge clk); core_take = 1'b0;
    rd(0, v); chk("R9 gie cleared", {6'd0, v[7], irq}, 8'h00);
    chk("R7 wake stays", {7'd0, wake}, 8'd1);
    @(negedge clk); ret_strobe = 1'b1;
    @(negedge clk); ret_strobe = 1'b0;
    rd(0, v); chk("R9 return sets gie", {6'd0, v[7], irq}, 8'h03);
    @(negedge clk); core_take = 1'b1; ret_strobe = 1'b1;
    @(negedge clk); core_take = 1'b0; ret_strobe = 1'b0;
    rd(0, v); chk("R9 clear priority", {7'd0, v[7]}, 8'd0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule